// File: doc/BRIEF.md
# Multi-Level Gate Drive Sequencer

This block sits between a PWM command and the gate stage of a power switch. It turns each switching edge into a timed series of gate-level selections. The raw command first passes a de-glitch filter. A rising command drives the gate through one intermediate level before full enhancement. A falling command steps the gate down through two intermediate levels before it reaches fully off. A desaturation trip takes a separate soft-shutdown path. That path has three wider steps and starts from the step at or below the level currently selected.

A fault-hold input stops any new turn-on. If the gate is active when fault-hold rises, the gate is brought down by the normal staircase. The output is a 3-bit encoded level select for the analog stage, plus a flag that is high while a staircase step is in progress. All durations are parameters given in nanoseconds. Each is rounded up to whole clock cycles; the clock runs at 100 MHz by default.

Top module: `gate_stager`

## Requirements
- R1: After reset `gate_lvl` is 0 (off) and `busy` is 0.
- R2: A change of `pwm_cmd` is accepted only after it has been sampled at 20 consecutive clock edges (200 ns). A change that lasts 19 cycles or fewer has no effect on `gate_lvl`.
- R3: Level codes: 0 off, 1 = 2.5 V, 2 = 4.5 V, 3 = 6.5 V, 4 = 9.5 V, 5 full on. On an accepted rising command, `gate_lvl` is 4 for 20 cycles, starting on the edge after the filter accepts, and then 5.
- R4: On an accepted falling command while fully on, `gate_lvl` is 4 for 20 cycles, then 2 for 20 cycles, then 0.
- R5: A staircase in progress always completes before the next accepted command edge is acted on. A pulse shorter than the turn-on staircase therefore still yields a complete turn-on.
- R6: A `desat_trip` sampled high while the gate is not off and no soft shutdown is running starts a soft shutdown on the next edge. The soft shutdown shows levels 4, 3 and 1 for 25 cycles each, then 0. It pre-empts turn-on, full-on and the first turn-off step. A trip while off has no effect.
- R7: A trip during the 4.5 V turn-off step enters the soft shutdown at its 2.5 V step (level 1), which lasts 25 cycles before off.
- R8: After a soft shutdown the gate stays off until the filtered command has been seen low. Only a later accepted rising command turns it on again.
- R9: While `fault_hold` is high, no turn-on starts. If the gate is fully on when `fault_hold` rises, the normal turn-off staircase of R4 begins on the next edge.
- R10: `busy` is 1 exactly when `gate_lvl` is neither 0 nor 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz by default |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | Raw PWM switching command |
| desat_trip | input | 1 | Desaturation trip request, sampled each cycle |
| fault_hold | input | 1 | Blocks turn-on while high |
| gate_lvl | output | 3 | Encoded gate level select |
| busy | output | 1 | A staircase step is in progress |

## Verification
The hardest cases to reach are the trips that land inside a particular staircase step. Examples are a trip during the 4.5 V turn-off step, or one part-way through turn-on. Each becomes reachable only after the 20-cycle filter delay and a full step duration. The bench therefore counts clock edges from the moment it changes an input. It applies the one-cycle trip at a computed offset inside the target step. It then samples the level on both sides of every expected step boundary. The re-arm rule is reached by holding the command high through a complete soft shutdown. The bench then drops and raises the command again.

// File: rtl/gstg_pkg.sv
package gstg_pkg;

   typedef enum logic [2:0] {
      LV_OFF  = 3'd0,
      LV_2V5  = 3'd1,
      LV_4V5  = 3'd2,
      LV_6V5  = 3'd3,
      LV_9V5  = 3'd4,
      LV_FULL = 3'd5
   } gate_lvl_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_RISE,
      ST_ON,
      ST_FALL1,
      ST_FALL2,
      ST_SOFT1,
      ST_SOFT2,
      ST_SOFT3
   } seq_st_e;

   function automatic gate_lvl_e lvl_of(input seq_st_e s);
      case (s)
         ST_RISE, ST_FALL1, ST_SOFT1: lvl_of = LV_9V5;
         ST_ON:                       lvl_of = LV_FULL;
         ST_FALL2:                    lvl_of = LV_4V5;
         ST_SOFT2:                    lvl_of = LV_6V5;
         ST_SOFT3:                    lvl_of = LV_2V5;
         default:                     lvl_of = LV_OFF;
      endcase
   endfunction

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      ns_to_cyc = (ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/gstg_deglitch.sv
module gstg_deglitch #(
   parameter int CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic filt
);
   generate
      if (CYC <= 1) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt <= 1'b0;
            else        filt <= raw;
         end
      end else begin : g_count
         localparam int CW = $clog2(CYC);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               filt <= 1'b0;
            end else if (raw == filt) begin
               cnt <= '0;
            end else if (cnt == CW'(CYC - 1)) begin
               cnt  <= '0;
               filt <= raw;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gstg_step_timer.sv
module gstg_step_timer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/gstg_seq.sv
module gstg_seq
   import gstg_pkg::*;
#(
   parameter int W        = 5,
   parameter int ON_CYC   = 20,
   parameter int OFF_CYC  = 20,
   parameter int SOFT_CYC = 25
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd,
   input  logic         trip,
   input  logic         hold,
   input  logic         expired,
   output seq_st_e      st,
   output logic         ld,
   output logic [W-1:0] ld_val
);
   localparam logic [W-1:0] ON_LD   = W'(ON_CYC - 1);
   localparam logic [W-1:0] OFF_LD  = W'(OFF_CYC - 1);
   localparam logic [W-1:0] SOFT_LD = W'(SOFT_CYC - 1);

   seq_st_e nxt;
   logic    rearm_q;
   logic    enter_soft;

   always_comb begin
      nxt        = st;
      ld         = 1'b0;
      ld_val     = '0;
      enter_soft = 1'b0;
      case (st)
         ST_OFF: begin
            if (cmd && !hold && !rearm_q) begin
               nxt = ST_RISE;  ld = 1'b1;  ld_val = ON_LD;
            end
         end
         ST_RISE, ST_ON, ST_FALL1: begin
            if (trip) begin
               nxt = ST_SOFT1;  ld = 1'b1;  ld_val = SOFT_LD;  enter_soft = 1'b1;
            end else if (st == ST_RISE) begin
               if (expired) nxt = ST_ON;
            end else if (st == ST_ON) begin
               if (!cmd || hold) begin
                  nxt = ST_FALL1;  ld = 1'b1;  ld_val = OFF_LD;
               end
            end else if (expired) begin
               nxt = ST_FALL2;  ld = 1'b1;  ld_val = OFF_LD;
            end
         end
         ST_FALL2: begin
            if (trip) begin
               nxt = ST_SOFT3;  ld = 1'b1;  ld_val = SOFT_LD;  enter_soft = 1'b1;
            end else if (expired) begin
               nxt = ST_OFF;
            end
         end
         ST_SOFT1: if (expired) begin nxt = ST_SOFT2; ld = 1'b1; ld_val = SOFT_LD; end
         ST_SOFT2: if (expired) begin nxt = ST_SOFT3; ld = 1'b1; ld_val = SOFT_LD; end
         ST_SOFT3: if (expired) nxt = ST_OFF;
         default:  nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OFF;
         rearm_q <= 1'b0;
      end else begin
         st <= nxt;
         if (enter_soft)  rearm_q <= 1'b1;
         else if (!cmd)   rearm_q <= 1'b0;
      end
   end
endmodule

// File: rtl/gate_stager.sv
module gate_stager
   import gstg_pkg::*;
#(
   parameter int CLK_NS     = 10,
   parameter int FILT_NS    = 200,
   parameter int ON_STEP_NS = 200,
   parameter int OFF_STEP_NS = 200,
   parameter int SOFT_STEP_NS = 250
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_cmd,
   input  logic       desat_trip,
   input  logic       fault_hold,
   output logic [2:0] gate_lvl,
   output logic       busy
);
   localparam int FILT_CYC = ns_to_cyc(FILT_NS, CLK_NS);
   localparam int ON_CYC   = ns_to_cyc(ON_STEP_NS, CLK_NS);
   localparam int OFF_CYC  = ns_to_cyc(OFF_STEP_NS, CLK_NS);
   localparam int SOFT_CYC = ns_to_cyc(SOFT_STEP_NS, CLK_NS);
   localparam int MAX_A    = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
   localparam int MAX_CYC  = (MAX_A > SOFT_CYC) ? MAX_A : SOFT_CYC;
   localparam int TW       = $clog2(MAX_CYC + 1);

   generate
      if (CLK_NS < 1)   begin : g_bad_clk  $error("CLK_NS must be positive"); end
      if (ON_CYC < 1)   begin : g_bad_on   $error("turn-on step must be at least one cycle"); end
      if (OFF_CYC < 1)  begin : g_bad_off  $error("turn-off step must be at least one cycle"); end
      if (SOFT_CYC < 1) begin : g_bad_soft $error("soft step must be at least one cycle"); end
   endgenerate

   logic          cmd_f;
   logic          tmr_ld;
   logic [TW-1:0] tmr_val;
   logic          tmr_exp;
   seq_st_e       st;

   gstg_deglitch #(.CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(pwm_cmd), .filt(cmd_f)
   );

   gstg_step_timer #(.W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_exp)
   );

   gstg_seq #(.W(TW), .ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC), .SOFT_CYC(SOFT_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_f), .trip(desat_trip), .hold(fault_hold),
      .expired(tmr_exp), .st(st), .ld(tmr_ld), .ld_val(tmr_val)
   );

   assign gate_lvl = lvl_of(st);
   assign busy     = !(st == ST_OFF || st == ST_ON);
endmodule

// File: rtl/gstg_checker.sv
module gstg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       pwm_cmd,
   input logic       desat_trip,
   input logic       fault_hold,
   input logic [2:0] gate_lvl,
   input logic       busy
);
   // R3
   lvl_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lvl <= 3'd5);

   // R3
   off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lvl == 3'd0) |=> (gate_lvl == 3'd0 || gate_lvl == 3'd4));

   // R4
   full_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lvl == 3'd5) |=> (gate_lvl == 3'd5 || gate_lvl == 3'd4));

   // R6
   trip_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lvl == 3'd5 && desat_trip) |=> (gate_lvl == 3'd4 && busy));

   // R9
   hold_keeps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lvl == 3'd0 && fault_hold) |=> (gate_lvl == 3'd0));

   // R10
   busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (gate_lvl != 3'd0 && gate_lvl != 3'd5));
endmodule

bind gate_stager gstg_checker u_chk (
   .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .desat_trip(desat_trip),
   .fault_hold(fault_hold), .gate_lvl(gate_lvl), .busy(busy)
);

// File: tb/gate_stager_bench.sv
module gate_stager_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_cmd = 1'b0;
   logic       desat_trip = 1'b0;
   logic       fault_hold = 1'b0;
   logic [2:0] gate_lvl;
   logic       busy;

   int n_chk = 0;
   int n_fail = 0;
   int edge_cnt = 0;
   int base = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   gate_stager u_gate_stager (
      .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .desat_trip(desat_trip),
      .fault_hold(fault_hold), .gate_lvl(gate_lvl), .busy(busy)
   );

   task automatic mark();
      base = edge_cnt;
   endtask

   task automatic at(input int k);
      while (edge_cnt < base + k) @(negedge clk);
   endtask

   task automatic chk(input string req, input int k, input int exp_lvl, input int exp_busy);
      at(k);
      n_chk++;
      if (gate_lvl != exp_lvl[2:0] || busy != exp_busy[0]) begin
         n_fail++;
         $display("FAIL %s at edge %0d: lvl=%0d busy=%0d expected lvl=%0d busy=%0d",
                  req, k, gate_lvl, busy, exp_lvl, exp_busy);
      end
   endtask

   task automatic trip_pulse();
      desat_trip = 1'b1;
      @(negedge clk);
      desat_trip = 1'b0;
   endtask

   task automatic settle();
      repeat (120) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", 0, 0, 0);
   endtask

   task automatic t_turn_on_off();
      pwm_cmd = 1'b1; mark();
      chk("R2", 20, 0, 0);
      chk("R3", 21, 4, 1);
      chk("R3", 40, 4, 1);
      chk("R3", 41, 5, 0);
      pwm_cmd = 1'b0; mark();
      chk("R4", 20, 5, 0);
      chk("R4", 21, 4, 1);
      chk("R4", 40, 4, 1);
      chk("R4", 41, 2, 1);
      chk("R4", 60, 2, 1);
      chk("R4", 61, 0, 0);
      settle();
   endtask

   task automatic t_glitch();
      pwm_cmd = 1'b1; mark();
      at(19); pwm_cmd = 1'b0;
      chk("R2", 40, 0, 0);
      chk("R2", 80, 0, 0);
      settle();
   endtask

   task automatic t_short_pulse();
      pwm_cmd = 1'b1; mark();
      at(20); pwm_cmd = 1'b0;
      chk("R5", 40, 4, 1);
      chk("R5", 41, 5, 0);
      chk("R5", 42, 4, 1);
      chk("R5", 62, 2, 1);
      chk("R5", 82, 0, 0);
      settle();
   endtask

   task automatic t_trip_full();
      pwm_cmd = 1'b1; mark();
      chk("R6", 50, 5, 0);
      mark(); trip_pulse();
      chk("R6", 1, 4, 1);
      chk("R6", 25, 4, 1);
      chk("R6", 26, 3, 1);
      chk("R6", 50, 3, 1);
      chk("R6", 51, 1, 1);
      chk("R6", 75, 1, 1);
      chk("R6", 76, 0, 0);
      chk("R8", 150, 0, 0);
      pwm_cmd = 1'b0; mark();
      chk("R8", 40, 0, 0);
      pwm_cmd = 1'b1; mark();
      chk("R8", 21, 4, 1);
      chk("R8", 41, 5, 0);
      pwm_cmd = 1'b0;
      settle();
   endtask

   task automatic t_trip_rise();
      pwm_cmd = 1'b1; mark();
      at(25); mark(); trip_pulse();
      chk("R6", 1, 4, 1);
      chk("R6", 26, 3, 1);
      chk("R6", 76, 0, 0);
      pwm_cmd = 1'b0;
      settle();
   endtask

   task automatic t_trip_fall2();
      pwm_cmd = 1'b1; mark();
      chk("R7", 50, 5, 0);
      pwm_cmd = 1'b0; mark();
      chk("R7", 45, 2, 1);
      mark(); trip_pulse();
      chk("R7", 1, 1, 1);
      chk("R7", 25, 1, 1);
      chk("R7", 26, 0, 0);
      settle();
   endtask

   task automatic t_trip_off();
      mark(); trip_pulse();
      chk("R6", 1, 0, 0);
      chk("R6", 30, 0, 0);
   endtask

   task automatic t_hold();
      fault_hold = 1'b1;
      pwm_cmd = 1'b1; mark();
      chk("R9", 80, 0, 0);
      fault_hold = 1'b0; mark();
      chk("R9", 1, 4, 1);
      chk("R9", 21, 5, 0);
      fault_hold = 1'b1; mark();
      chk("R9", 1, 4, 1);
      chk("R9", 21, 2, 1);
      chk("R9", 41, 0, 0);
      chk("R9", 100, 0, 0);
      pwm_cmd = 1'b0;
      fault_hold = 1'b0;
      settle();
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_turn_on_off();
      t_glitch();
      t_short_pulse();
      t_trip_full();
      t_trip_rise();
      t_trip_fall2();
      t_trip_off();
      t_hold();
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      finish_up();
   end
endmodule